// File: doc/BRIEF.md
# IN-direction write decoder with header addressing

This block sits between a byte-wide serial receiver and the IN-side transmit buffers of a low-speed USB device bridge. The microcontroller opens every write with a single header byte. That byte carries three things: the DATA0/DATA1 toggle for the packet, a 3-bit destination address, and a 4-bit payload length. The decoder reads the header. It then sends the payload bytes that follow either into one of the IN FIFOs or into a small internal register bank.

Once a FIFO has been filled, it stays locked for the USB transmit side until that FIFO's acknowledge lane pulses. A header with a zero count is a real zero-length packet, and it locks the FIFO in the same way. A rising SETUP flag flushes every IN FIFO and clears the two EP0 stall bits. The block does not handle bit-level shifting or packet transmission.

Top module: `in_wr_decoder`

## Requirements
- R1: The header is byte bit 7 = toggle (1 = DATA1), bits 6:4 = destination address, bits 3:0 = count. Addresses 0..NUM_FIFOS-1 select IN FIFOs. A FIFO header with count 0..DEPTH loads that FIFO's toggle and length on the edge that takes the header.
- R2: For a FIFO header with count n in 1..DEPTH, the next n valid bytes are stored at indices 0..n-1 in arrival order. The FIFO becomes blocked on the edge that takes byte n, and not before.
- R3: A FIFO header with count 0 blocks that FIFO on the header edge, with length 0.
- R4: A blocked FIFO is released only by a pulse on its own ack lane. An ack to an unblocked FIFO changes nothing.
- R5: A header to a blocked FIFO raises overrun_o for one cycle and leaves that FIFO's length, toggle and data unchanged. Its count bytes are then discarded and not decoded as headers.
- R6: A FIFO header with count 9..15 raises count_err_o for one cycle and writes nothing. The next byte is decoded as a header.
- R7: A header addressing a register (address NUM_FIFOS..7) is followed by exactly one data byte, whatever its count. That byte is written to register index address-NUM_FIFOS, and no error is raised.
- R8: On a rising edge of setup_i, every FIFO is unblocked with length 0 and toggle 0. A FIFO load in progress is abandoned, and its remaining bytes are discarded.
- R9: Register index 0 is the stall register, with bit 0 = EP0 IN stall and bit 1 = EP0 OUT stall. A rising edge of setup_i clears those two bits, keeps the rest, and wins over a same-cycle write. Holding setup_i high has no further effect.
- R10: After reset, every FIFO is unblocked with length 0, toggle 0 and zero data, every register is 0, both pulse flags are low, and the decoder waits for a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | byte_i holds a received byte this cycle |
| byte_i | input | 8 | Received byte (header or payload) |
| ack_i | input | NUM_FIFOS | Per-FIFO host acknowledge pulse |
| setup_i | input | 1 | SETUP flag level; rising edge flushes |
| fifo_blocked_o | output | NUM_FIFOS | FIFO loaded and waiting for ack |
| fifo_toggle_o | output | NUM_FIFOS | Toggle bit of each FIFO's packet |
| fifo_len_o | output | NUM_FIFOS*LEN_W | Packet length; FIFO i at [i*LEN_W +: LEN_W] |
| fifo_data_o | output | NUM_FIFOS*DEPTH*8 | FIFO i byte j at [(i*DEPTH+j)*8 +: 8] |
| regs_o | output | NUM_REGS*8 | Register k at [k*8 +: 8] |
| count_err_o | output | 1 | One-cycle pulse: FIFO count out of range |
| overrun_o | output | 1 | One-cycle pulse: write to blocked FIFO |

## Verification
The bench uses the default parameters: three IN FIFOs of depth eight, which leaves five register addresses. With DEPTH at eight, a full 8-byte load sits right beside the rejected count of 9. With three FIFOs, the bench can hold one FIFO blocked while it loads another, and it can send acks to blocked and unblocked lanes in the same run. The five register slots let the bench test a register header whose count field would be illegal for a FIFO. They also let it write the stall register while setup_i is held high.

// File: rtl/in_wr_pkg.sv
package in_wr_pkg;
  localparam int HDR_CNT_W  = 4;
  localparam int HDR_ADDR_W = 3;

  typedef struct packed {
    logic                  tog;
    logic [HDR_ADDR_W-1:0] addr;
    logic [HDR_CNT_W-1:0]  cnt;
  } hdr_t;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_LOAD,
    ST_REG,
    ST_SKIP
  } wr_state_e;
endpackage

// File: rtl/in_wr_hdr_decode.sv
module in_wr_hdr_decode
  import in_wr_pkg::*;
#(
  parameter int NUM_FIFOS = 3,
  parameter int DEPTH     = 8,
  parameter int REG_IDX_W = 3
) (
  input  logic [7:0]           byte_i,
  output logic                 tog_o,
  output logic [HDR_CNT_W-1:0] cnt_o,
  output logic                 is_fifo_o,
  output logic [NUM_FIFOS-1:0] fifo_sel_o,
  output logic [REG_IDX_W-1:0] reg_idx_o,
  output logic                 cnt_bad_o,
  output logic                 cnt_zero_o
);
  hdr_t hdr;
  logic [HDR_ADDR_W-1:0] reg_off;

  assign hdr        = hdr_t'(byte_i);
  assign tog_o      = hdr.tog;
  assign cnt_o      = hdr.cnt;
  assign is_fifo_o  = int'(hdr.addr) < NUM_FIFOS;
  assign reg_off    = hdr.addr - HDR_ADDR_W'(NUM_FIFOS);
  assign reg_idx_o  = REG_IDX_W'(reg_off);
  // count range only matters for FIFO destinations
  assign cnt_bad_o  = is_fifo_o && (int'(hdr.cnt) > DEPTH);
  assign cnt_zero_o = (hdr.cnt == '0);

  for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_sel
    assign fifo_sel_o[g] = (hdr.addr == HDR_ADDR_W'(g));
  end
endmodule

// File: rtl/in_wr_fifo_slot.sv
module in_wr_fifo_slot #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               start_tog_i,
  input  logic [LEN_W-1:0]   start_len_i,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [7:0]         wr_byte_i,
  input  logic               seal_i,
  input  logic               ack_i,
  input  logic               flush_i,
  output logic               blocked_o,
  output logic               tog_o,
  output logic [LEN_W-1:0]   len_o,
  output logic [DEPTH*8-1:0] data_o
);
  logic [DEPTH-1:0][7:0] mem_q;
  logic                  blocked_q, tog_q;
  logic [LEN_W-1:0]      len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blocked_q <= 1'b0;
      tog_q     <= 1'b0;
      len_q     <= '0;
    end else if (flush_i) begin
      blocked_q <= 1'b0;
      tog_q     <= 1'b0;
      len_q     <= '0;
    end else begin
      if (start_i) begin
        tog_q <= start_tog_i;
        len_q <= start_len_i;
      end
      if (seal_i)                blocked_q <= 1'b1;
      else if (ack_i && blocked_q) blocked_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mem_q <= '0;
    else if (wr_i) mem_q[wr_idx_i] <= wr_byte_i;
  end

  assign blocked_o = blocked_q;
  assign tog_o     = tog_q;
  assign len_o     = len_q;
  assign data_o    = mem_q;

  // R5
  no_write_when_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_q |-> !(wr_i || start_i || seal_i));
  // R4
  ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked_q && ack_i && !flush_i) |=> !blocked_o);
  // R8
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!blocked_o && len_o == '0 && !tog_o));
endmodule

// File: rtl/in_wr_reg_bank.sv
module in_wr_reg_bank #(
  parameter int NUM_REGS  = 5,
  parameter int REG_IDX_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [REG_IDX_W-1:0]  idx_i,
  input  logic [7:0]            data_i,
  input  logic                  clr_stall_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [NUM_REGS-1:0][7:0] regs_q;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic hit;
    assign hit = wr_i && (idx_i == REG_IDX_W'(k));
    if (k == 0) begin : g_stall
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[k] <= '0;
        else begin
          if (hit) regs_q[k] <= clr_stall_i ? {data_i[7:2], 2'b00} : data_i;
          else if (clr_stall_i) regs_q[k][1:0] <= 2'b00;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  regs_q[k] <= '0;
        else if (hit) regs_q[k] <= data_i;
      end
    end
  end

  assign regs_o = regs_q;

  // R9
  stall_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_stall_i |=> (regs_o[1:0] == 2'b00));
endmodule

// File: rtl/in_wr_decoder.sv
module in_wr_decoder
  import in_wr_pkg::*;
#(
  parameter int NUM_FIFOS = 3,
  parameter int DEPTH     = 8,
  localparam int LEN_W    = $clog2(DEPTH + 1),
  localparam int NUM_REGS = 8 - NUM_FIFOS
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           byte_valid_i,
  input  logic [7:0]                     byte_i,
  input  logic [NUM_FIFOS-1:0]           ack_i,
  input  logic                           setup_i,
  output logic [NUM_FIFOS-1:0]           fifo_blocked_o,
  output logic [NUM_FIFOS-1:0]           fifo_toggle_o,
  output logic [NUM_FIFOS*LEN_W-1:0]     fifo_len_o,
  output logic [NUM_FIFOS*DEPTH*8-1:0]   fifo_data_o,
  output logic [NUM_REGS*8-1:0]          regs_o,
  output logic                           count_err_o,
  output logic                           overrun_o
);
  localparam int IDX_W     = $clog2(DEPTH);
  localparam int FIFO_W    = (NUM_FIFOS > 1) ? $clog2(NUM_FIFOS) : 1;
  localparam int REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  wr_state_e              state_q, state_d;
  logic [HDR_CNT_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]       ptr_q, ptr_d;
  logic [FIFO_W-1:0]      dst_q, dst_d;
  logic [REG_IDX_W-1:0]   ridx_q, ridx_d;
  logic                   setup_q, setup_rise;
  logic                   err_q, ovr_q;

  logic                   h_tog, h_fifo, h_bad, h_zero;
  logic [HDR_CNT_W-1:0]   h_cnt;
  logic [NUM_FIFOS-1:0]   h_sel;
  logic [REG_IDX_W-1:0]   h_ridx;
  logic [FIFO_W-1:0]      h_fidx;

  logic hdr_take, sel_blocked, start_ok, load_wr, last_byte, reg_wr;

  in_wr_hdr_decode #(
    .NUM_FIFOS(NUM_FIFOS), .DEPTH(DEPTH), .REG_IDX_W(REG_IDX_W)
  ) u_hdr (
    .byte_i    (byte_i),
    .tog_o     (h_tog),
    .cnt_o     (h_cnt),
    .is_fifo_o (h_fifo),
    .fifo_sel_o(h_sel),
    .reg_idx_o (h_ridx),
    .cnt_bad_o (h_bad),
    .cnt_zero_o(h_zero)
  );

  assign h_fidx      = FIFO_W'(byte_i[6:4]);
  assign setup_rise  = setup_i && !setup_q;
  assign hdr_take    = byte_valid_i && (state_q == ST_HDR);
  assign sel_blocked = |(h_sel & fifo_blocked_o);
  assign start_ok    = hdr_take && h_fifo && !h_bad && !sel_blocked;
  assign load_wr     = byte_valid_i && (state_q == ST_LOAD);
  assign last_byte   = (cnt_q == HDR_CNT_W'(1));
  assign reg_wr      = byte_valid_i && (state_q == ST_REG);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ptr_d   = ptr_q;
    dst_d   = dst_q;
    ridx_d  = ridx_q;
    if (byte_valid_i) begin
      unique case (state_q)
        ST_HDR: begin
          if (!h_fifo) begin
            state_d = ST_REG;
            ridx_d  = h_ridx;
          end else if (!h_bad && !h_zero) begin
            state_d = sel_blocked ? ST_SKIP : ST_LOAD;
            cnt_d   = h_cnt;
            ptr_d   = '0;
            dst_d   = h_fidx;
          end
        end
        ST_LOAD: begin
          cnt_d = cnt_q - 1'b1;
          ptr_d = ptr_q + 1'b1;
          if (last_byte) state_d = ST_HDR;
        end
        ST_SKIP: begin
          cnt_d = cnt_q - 1'b1;
          if (last_byte) state_d = ST_HDR;
        end
        default: state_d = ST_HDR;
      endcase
    end
    // flush abandons a load; drain the rest of it
    if (setup_rise && state_d == ST_LOAD) state_d = ST_SKIP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      cnt_q   <= '0;
      ptr_q   <= '0;
      dst_q   <= '0;
      ridx_q  <= '0;
      setup_q <= 1'b0;
      err_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ptr_q   <= ptr_d;
      dst_q   <= dst_d;
      ridx_q  <= ridx_d;
      setup_q <= setup_i;
      err_q   <= hdr_take && h_bad;
      ovr_q   <= hdr_take && h_fifo && !h_bad && sel_blocked;
    end
  end

  for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_fifo
    logic here_hdr, here_load;
    assign here_hdr  = start_ok && h_sel[g];
    assign here_load = load_wr && (dst_q == FIFO_W'(g));

    in_wr_fifo_slot #(.DEPTH(DEPTH)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (here_hdr),
      .start_tog_i(h_tog),
      .start_len_i(LEN_W'(h_cnt)),
      .wr_i       (here_load),
      .wr_idx_i   (ptr_q),
      .wr_byte_i  (byte_i),
      .seal_i     ((here_hdr && h_zero) || (here_load && last_byte)),
      .ack_i      (ack_i[g]),
      .flush_i    (setup_rise),
      .blocked_o  (fifo_blocked_o[g]),
      .tog_o      (fifo_toggle_o[g]),
      .len_o      (fifo_len_o[g*LEN_W +: LEN_W]),
      .data_o     (fifo_data_o[g*DEPTH*8 +: DEPTH*8])
    );
  end

  in_wr_reg_bank #(.NUM_REGS(NUM_REGS), .REG_IDX_W(REG_IDX_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr),
    .idx_i      (ridx_q),
    .data_i     (byte_i),
    .clr_stall_i(setup_rise),
    .regs_o     (regs_o)
  );

  assign count_err_o = err_q;
  assign overrun_o   = ovr_q;

  // R6
  count_err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_err_o |-> ($past(byte_valid_i) && int'($past(byte_i[3:0])) > DEPTH));
  // R5
  overrun_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> ($past(fifo_blocked_o) != '0));
  // R6
  no_dual_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(count_err_o && overrun_o));
endmodule

// File: tb/in_wr_decoder_bench.sv
module in_wr_decoder_bench;
  localparam int NF    = 3;
  localparam int DEP   = 8;
  localparam int LW    = 4;
  localparam int NR    = 8 - NF;
  localparam int S_HDR = 0, S_LOAD = 1, S_REG = 2, S_SKIP = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bv = 1'b0;
  logic [7:0]      bdat = '0;
  logic [NF-1:0]   ack = '0;
  logic            setup = 1'b0;
  logic [NF-1:0]   blk_o, tog_o;
  logic [NF*LW-1:0]    len_o;
  logic [NF*DEP*8-1:0] data_o;
  logic [NR*8-1:0]     regs_o;
  logic            err_o, ovr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  in_wr_decoder u_in_wr_decoder (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .byte_i(bdat),
    .ack_i(ack), .setup_i(setup), .fifo_blocked_o(blk_o),
    .fifo_toggle_o(tog_o), .fifo_len_o(len_o), .fifo_data_o(data_o),
    .regs_o(regs_o), .count_err_o(err_o), .overrun_o(ovr_o)
  );

  always #5 clk = ~clk;

  // reference model
  int m_state, m_cnt, m_dst, m_ptr, m_ridx;
  int m_blk[NF], m_len[NF], m_tog[NF];
  int m_data[NF][DEP];
  int m_regs[NR];
  int m_err, m_ovr, m_sq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = S_HDR; m_cnt = 0; m_dst = 0; m_ptr = 0; m_ridx = 0;
      m_err = 0; m_ovr = 0; m_sq = 0;
      for (int i = 0; i < NF; i++) begin
        m_blk[i] = 0; m_len[i] = 0; m_tog[i] = 0;
        for (int j = 0; j < DEP; j++) m_data[i][j] = 0;
      end
      for (int k = 0; k < NR; k++) m_regs[k] = 0;
    end else begin
      int rise, a, c;
      int pre[NF];
      rise = (setup && !m_sq) ? 1 : 0;
      m_sq = setup;
      m_err = 0; m_ovr = 0;
      for (int i = 0; i < NF; i++) pre[i] = m_blk[i];
      if (bv) begin
        if (m_state == S_HDR) begin
          a = int'(bdat[6:4]); c = int'(bdat[3:0]);
          if (a >= NF) begin
            m_state = S_REG; m_ridx = a - NF;
          end else if (c > DEP) m_err = 1;
          else if (pre[a] != 0) begin
            m_ovr = 1;
            if (c != 0) begin m_state = S_SKIP; m_cnt = c; end
          end else begin
            m_tog[a] = int'(bdat[7]); m_len[a] = c;
            if (c == 0) m_blk[a] = 1;
            else begin m_state = S_LOAD; m_cnt = c; m_dst = a; m_ptr = 0; end
          end
        end else if (m_state == S_LOAD) begin
          m_data[m_dst][m_ptr] = int'(bdat);
          m_ptr++;
          if (m_cnt == 1) begin m_blk[m_dst] = 1; m_state = S_HDR; end
          m_cnt--;
        end else if (m_state == S_SKIP) begin
          if (m_cnt == 1) m_state = S_HDR;
          m_cnt--;
        end else begin
          m_regs[m_ridx] = int'(bdat); m_state = S_HDR;
        end
      end
      for (int i = 0; i < NF; i++) if (ack[i] && pre[i] != 0) m_blk[i] = 0;
      if (rise != 0) begin
        for (int i = 0; i < NF; i++) begin m_blk[i] = 0; m_len[i] = 0; m_tog[i] = 0; end
        m_regs[0] = m_regs[0] & 'hFC;
        if (m_state == S_LOAD) m_state = S_SKIP;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < NF; i++) begin
        chk("R2", $sformatf("blocked[%0d]", i), int'(blk_o[i]), m_blk[i]);
        chk("R1", $sformatf("len[%0d]", i), int'(len_o[i*LW +: LW]), m_len[i]);
        chk("R1", $sformatf("tog[%0d]", i), int'(tog_o[i]), m_tog[i]);
        for (int j = 0; j < DEP; j++)
          chk("R2", $sformatf("data[%0d][%0d]", i, j),
              int'(data_o[(i*DEP+j)*8 +: 8]), m_data[i][j]);
      end
      for (int k = 0; k < NR; k++)
        chk("R7", $sformatf("reg[%0d]", k), int'(regs_o[k*8 +: 8]), m_regs[k]);
      chk("R6", "count_err", int'(err_o), m_err);
      chk("R5", "overrun", int'(ovr_o), m_ovr);
    end
  end

  task automatic send(input logic [7:0] b);
    bv = 1'b1; bdat = b;
    @(negedge clk);
    bv = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_pulse(input logic [NF-1:0] m);
    ack = m;
    @(negedge clk);
    ack = '0;
  endtask

  function automatic int dbyte(input int f, input int j);
    return int'(data_o[(f*DEP+j)*8 +: 8]);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(2);
    // R10 reset state
    chk("R10", "blocked at reset", int'(blk_o), 0);
    chk("R10", "regs at reset", int'(regs_o != '0), 0);
    chk("R10", "data at reset", int'(data_o != '0), 0);
    chk("R10", "flags at reset", int'({err_o, ovr_o}), 0);
    rst_n = 1'b1;
    idle(2);

    // R1 R2: FIFO0, DATA1, three bytes
    send(8'h83);
    chk("R1", "tog0 after header", int'(tog_o[0]), 1);
    chk("R1", "len0 after header", int'(len_o[0 +: LW]), 3);
    send(8'h11); send(8'h22);
    chk("R2", "fifo0 not yet blocked", int'(blk_o[0]), 0);
    send(8'h33);
    chk("R2", "fifo0 blocked on last byte", int'(blk_o), 3'b001);
    chk("R2", "fifo0 byte2", dbyte(0, 2), 'h33);

    // R5: write to blocked FIFO0, then FIFO1 header right after the skipped bytes
    send(8'h02);
    chk("R5", "overrun pulse", int'(ovr_o), 1);
    send(8'hAA); send(8'hBB);
    chk("R5", "overrun one cycle", int'(ovr_o), 0);
    chk("R5", "fifo0 byte0 kept", dbyte(0, 0), 'h11);
    chk("R5", "fifo0 len kept", int'(len_o[0 +: LW]), 3);
    send(8'h11); send(8'h5A);
    chk("R5", "fifo1 loaded after skip", int'(blk_o), 3'b011);
    chk("R5", "fifo1 byte0", dbyte(1, 0), 'h5A);

    // R4: acks
    ack_pulse(3'b100);
    chk("R4", "ack to unblocked lane", int'(blk_o), 3'b011);
    ack_pulse(3'b010);
    chk("R4", "ack lane1", int'(blk_o), 3'b001);
    idle(1);
    ack_pulse(3'b001);
    chk("R4", "ack lane0", int'(blk_o), 3'b000);

    // R3: zero length to FIFO2 with DATA1
    send(8'hA0);
    chk("R3", "fifo2 blocked zero len", int'(blk_o), 3'b100);
    chk("R3", "fifo2 len", int'(len_o[2*LW +: LW]), 0);
    chk("R3", "fifo2 tog", int'(tog_o[2]), 1);

    // R6: count 9 rejected, next byte is a header
    send(8'h09);
    chk("R6", "count_err pulse", int'(err_o), 1);
    chk("R6", "fifo0 untouched", int'(len_o[0 +: LW]), 3);
    send(8'h01); send(8'h77);
    chk("R6", "header after reject", int'(blk_o), 3'b101);
    chk("R6", "fifo0 byte0", dbyte(0, 0), 'h77);

    // R7: register writes, count field ignored
    send(8'h3F); send(8'hFF);
    chk("R7", "stall reg", int'(regs_o[7:0]), 'hFF);
    chk("R7", "no error for reg header", int'(err_o), 0);
    send(8'h75); send(8'hC3);
    chk("R7", "reg4", int'(regs_o[4*8 +: 8]), 'hC3);
    send(8'h4A); send(8'h12);
    chk("R7", "reg1", int'(regs_o[15:8]), 'h12);

    // R8 R9: setup rise
    setup = 1'b1;
    idle(1);
    chk("R9", "stall bits cleared", int'(regs_o[7:0]), 'hFC);
    chk("R8", "all unblocked", int'(blk_o), 0);
    chk("R8", "lens cleared", int'(len_o), 0);
    chk("R8", "toggles cleared", int'(tog_o), 0);
    send(8'h3F); send(8'h03);
    idle(2);
    chk("R9", "held setup no effect", int'(regs_o[7:0]), 'h03);
    setup = 1'b0;
    idle(1);

    // R8: load abandoned mid-way
    send(8'h84); send(8'h01); send(8'h02);
    setup = 1'b1;
    idle(1);
    send(8'h03); send(8'h04);
    send(8'h10);
    chk("R8", "remaining bytes discarded", int'(blk_o), 3'b010);
    chk("R8", "fifo0 flushed", int'(len_o[0 +: LW]), 0);
    setup = 1'b0;
    ack_pulse(3'b010);

    // R2: full depth load
    send(8'h88);
    for (int j = 0; j < DEP - 1; j++) send(8'(8'hE0 + j));
    chk("R2", "not blocked before byte 8", int'(blk_o[0]), 0);
    send(8'hE7);
    chk("R2", "blocked after byte 8", int'(blk_o[0]), 1);
    chk("R2", "len 8", int'(len_o[0 +: LW]), 8);
    chk("R2", "last byte", dbyte(0, 7), 'hE7);
    idle(3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule